// File: doc/BRIEF.md
# Secondary Clock Output Gating Controller

This block drives a bank of secondary clock outputs, all copies of one input clock, and decides for each output whether it toggles, is parked at a constant high level, or is forced low. An enabled output follows the input clock in phase. The parking decision comes from a disable mask. The mask is filled bit by bit from a serial input during a short window near reset, and a simple register port can also read and overwrite it.

On top of the mask sits a power-management override. When a strap input allows it and the power state reports D3hot, every output is forced to 0. Changes to the gating take effect only while the input clock is low, so no output ever produces a shortened high pulse.

The serial window opens once the primary reset is seen released while the secondary reset is still held. One mask bit is taken on each rising edge of a shift strobe. Capture ends after a full mask has arrived or when the secondary reset is released, whichever happens first. It does not reopen until the next block reset.

Top module: `sec_clk_gate_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, every mask bit reads 0 and every output follows the input clock.
- R2: Output i, when its mask bit is 0 and the override is inactive, is high during the high phase of `clk` and low during the low phase.
- R3: Output i, when its mask bit is 1 and the override is inactive, stays at 1 through both clock phases. Holding the serial input high for a whole stream therefore parks every output high.
- R4: The capture window opens only at a clock edge where `pri_rst_act` is 0 and `sec_rst_act` is 1. Strobes seen before the window opens do not change the mask.
- R5: Inside the window, each rising edge of `ser_stb` stores `ser_din` into the next mask bit. The first received bit goes to bit 0, the second to bit 1, and so on.
- R6: Capture ends after NUM_OUT bits. Any later strobes leave the mask unchanged.
- R7: If `sec_rst_act` falls before all bits have arrived, capture ends at once. The bits already stored are kept, the rest keep their previous value, and the window stays closed until `rst`.
- R8: A cycle with `reg_we`=1 loads `reg_wdata` into the mask, and this write wins over a serial bit in the same cycle. `reg_rdata` always returns the current mask.
- R9: With `ovr_strap`=1 and `pwr_state`=2'b11 (D3hot), every output is 0 in both clock phases, whatever the mask holds.
- R10: With `ovr_strap`=0, or with any `pwr_state` other than 2'b11, the power state has no effect on the outputs.
- R11: A change of mask or override takes effect at the next falling edge of `clk`. A high phase that is already in progress completes at full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock for all outputs and for the control logic |
| rst | input | 1 | Synchronous active-high block reset |
| pri_rst_act | input | 1 | Primary-side reset indication, 1 = asserted |
| sec_rst_act | input | 1 | Secondary-side reset indication, 1 = asserted |
| ser_din | input | 1 | Serial mask data |
| ser_stb | input | 1 | Shift strobe; each rising edge takes one bit |
| pwr_state | input | 2 | Power state, 2'b11 = D3hot |
| ovr_strap | input | 1 | Enables the D3hot force-low override |
| reg_we | input | 1 | Register write enable for the mask |
| reg_wdata | input | NUM_OUT | Mask value to write |
| reg_rdata | output | NUM_OUT | Current mask value |
| clk_out | output | NUM_OUT | Gated clock outputs |

## Verification
The bench sweeps all 1024 mask values through the register port and compares both clock phases of every output with values computed from the mask. A swapped park level or a polarity error in the mask would show up as an output that is stuck or inverted.

Serial streams cover several cases. One has extra bits past the limit, which a counter that fails to stop would shift into the mask. One is cut short by the secondary reset, which a window that reopens would later overwrite. Another is sent before the window opens, which an early-opening window would capture.

The eight combinations of strap and power state check that only the single D3hot-with-strap case forces outputs low. A final check drives the override mid-way through a high phase and samples before the falling edge. A gate that switched at once would cut that pulse short.

// File: rtl/sec_clk_pkg.sv
package sec_clk_pkg;

    typedef enum logic [1:0] {
        PWR_D0     = 2'b00,
        PWR_D1     = 2'b01,
        PWR_D2     = 2'b10,
        PWR_D3_HOT = 2'b11
    } pwr_state_e;

    typedef enum logic [1:0] {
        CAP_IDLE  = 2'b00,
        CAP_SHIFT = 2'b01,
        CAP_DONE  = 2'b10
    } cap_state_e;

    typedef struct packed {
        logic force_low;
        logic park_high;
    } gate_ctl_t;

    function automatic logic d3_forces_low(input logic strap, input logic [1:0] state);
        return strap && (state == PWR_D3_HOT);
    endfunction

    function automatic logic window_open(input logic pri_act, input logic sec_act);
        return !pri_act && sec_act;
    endfunction

endpackage

// File: rtl/sec_clk_mask_capture.sv
module sec_clk_mask_capture
    import sec_clk_pkg::*;
#(
    parameter int NUM_OUT = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pri_rst_act,
    input  logic               sec_rst_act,
    input  logic               ser_din,
    input  logic               ser_stb,
    input  logic               reg_we,
    input  logic [NUM_OUT-1:0] reg_wdata,
    output logic [NUM_OUT-1:0] mask
);
    localparam int CNT_W = $clog2(NUM_OUT + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_OUT - 1);

    cap_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             stb_q;
    logic             stb_rise;
    logic [NUM_OUT-1:0] mask_q;
    logic [NUM_OUT-1:0] mask_d;

    assign stb_rise = ser_stb && !stb_q;

    always_comb begin
        mask_d = mask_q;
        if (state_q == CAP_SHIFT && sec_rst_act && stb_rise) begin
            for (int i = 0; i < NUM_OUT; i++) begin
                if (cnt_q == CNT_W'(i)) mask_d[i] = ser_din;
            end
        end
        if (reg_we) mask_d = reg_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CAP_IDLE;
            cnt_q   <= '0;
            stb_q   <= 1'b0;
            mask_q  <= '0;
        end else begin
            stb_q  <= ser_stb;
            mask_q <= mask_d;
            case (state_q)
                CAP_IDLE: begin
                    if (window_open(pri_rst_act, sec_rst_act)) begin
                        state_q <= CAP_SHIFT;
                        cnt_q   <= '0;
                    end
                end
                CAP_SHIFT: begin
                    if (!sec_rst_act) begin
                        state_q <= CAP_DONE;
                    end else if (stb_rise) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == LAST_IDX) state_q <= CAP_DONE;
                    end
                end
                default: state_q <= CAP_DONE;
            endcase
        end
    end

    assign mask = mask_q;

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(NUM_OUT));

    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        state_q == CAP_DONE |=> state_q == CAP_DONE);

    // R4
    window_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == CAP_IDLE && !window_open(pri_rst_act, sec_rst_act)) |=> state_q == CAP_IDLE);

    // R8
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!reg_we && state_q != CAP_SHIFT) |=> $stable(mask_q));

endmodule

// File: rtl/sec_clk_gate_cell.sv
module sec_clk_gate_cell
    import sec_clk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  gate_ctl_t ctl,
    output logic      gclk
);
    gate_ctl_t ctl_q;

    always_ff @(negedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl;
        end
    end

    always_comb begin
        if (ctl_q.force_low)      gclk = 1'b0;
        else if (ctl_q.park_high) gclk = 1'b1;
        else                      gclk = clk;
    end

endmodule

// File: rtl/sec_clk_gate_ctrl.sv
module sec_clk_gate_ctrl
    import sec_clk_pkg::*;
#(
    parameter int NUM_OUT = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pri_rst_act,
    input  logic               sec_rst_act,
    input  logic               ser_din,
    input  logic               ser_stb,
    input  logic [1:0]         pwr_state,
    input  logic               ovr_strap,
    input  logic               reg_we,
    input  logic [NUM_OUT-1:0] reg_wdata,
    output logic [NUM_OUT-1:0] reg_rdata,
    output logic [NUM_OUT-1:0] clk_out
);
    logic [NUM_OUT-1:0] mask;
    logic               force_req;

    assign force_req = d3_forces_low(ovr_strap, pwr_state);

    sec_clk_mask_capture #(.NUM_OUT(NUM_OUT)) u_cap (
        .clk         (clk),
        .rst         (rst),
        .pri_rst_act (pri_rst_act),
        .sec_rst_act (sec_rst_act),
        .ser_din     (ser_din),
        .ser_stb     (ser_stb),
        .reg_we      (reg_we),
        .reg_wdata   (reg_wdata),
        .mask        (mask)
    );

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        gate_ctl_t ctl;
        assign ctl.force_low = force_req;
        assign ctl.park_high = mask[g];
        sec_clk_gate_cell u_gate (
            .clk  (clk),
            .rst  (rst),
            .ctl  (ctl),
            .gclk (clk_out[g])
        );
    end

    assign reg_rdata = mask;

    // R9
    force_low_chk: assert property (@(posedge clk) disable iff (rst)
        (force_req && $past(force_req)) |-> clk_out == '0);

    // R2
    low_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (!force_req && $past(!force_req) && $stable(mask)) |-> clk_out == mask);

    // R3
    park_high_chk: assert property (@(posedge clk) disable iff (rst)
        (!force_req && $past(!force_req) && mask == '1 && $stable(mask)) |-> clk_out == '1);

endmodule

// File: tb/sec_clk_gate_ctrl_test.sv
module sec_clk_gate_ctrl_test;
    localparam int N = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         pri_rst_act, sec_rst_act, ser_din, ser_stb, ovr_strap, reg_we;
    logic [1:0]   pwr_state;
    logic [N-1:0] reg_wdata, reg_rdata, clk_out;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    sec_clk_gate_ctrl #(.NUM_OUT(N)) uut (
        .clk(clk), .rst(rst), .pri_rst_act(pri_rst_act), .sec_rst_act(sec_rst_act),
        .ser_din(ser_din), .ser_stb(ser_stb), .pwr_state(pwr_state), .ovr_strap(ovr_strap),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_out(clk_out)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Samples one high phase and the following low phase.
    task automatic chk_out(input string req, input logic [N-1:0] m, input logic frc);
        logic [N-1:0] exp_hi, exp_lo;
        exp_hi = frc ? '0 : '1;
        exp_lo = frc ? '0 : m;
        @(posedge clk); #2;
        chk({req, " high"}, clk_out, exp_hi);
        @(negedge clk); #2;
        chk({req, " low"}, clk_out, exp_lo);
    endtask

    task automatic do_reset;
        @(posedge clk); #1;
        rst = 1; pri_rst_act = 1; sec_rst_act = 1; ser_din = 0; ser_stb = 0;
        reg_we = 0; reg_wdata = '0; ovr_strap = 0; pwr_state = 2'b00;
        cyc(3);
        rst = 0;
        cyc(1);
    endtask

    task automatic send_bit(input logic b);
        ser_din = b; ser_stb = 1;
        cyc(2);
        ser_stb = 0;
        cyc(2);
    endtask

    task automatic reg_write(input logic [N-1:0] v);
        reg_we = 1; reg_wdata = v;
        cyc(1);
        reg_we = 0;
    endtask

    initial begin
        logic [N-1:0] pat;
        do_reset();

        // R1: reset state
        chk("R1 mask after reset", reg_rdata, '0);
        chk_out("R1 outputs after reset", '0, 0);

        // R4: strobes before the window opens are ignored
        send_bit(1); send_bit(1); send_bit(1);
        chk("R4 closed window", reg_rdata, '0);

        // R5, R6: open window, ten bits then two extra ones
        pri_rst_act = 0;
        cyc(2);
        pat = 10'b1011001110;
        for (int i = 0; i < N; i++) send_bit(pat[i]);
        send_bit(1); send_bit(1);
        chk("R5 R6 serial order and limit", reg_rdata, pat);
        chk_out("R3 mixed mask outputs", pat, 0);
        sec_rst_act = 0;
        cyc(2);
        send_bit(0);
        chk("R6 no capture after done", reg_rdata, pat);

        // R7: early stop on secondary reset release
        do_reset();
        pri_rst_act = 0;
        cyc(2);
        send_bit(1); send_bit(0); send_bit(1); send_bit(1);
        sec_rst_act = 0;
        cyc(2);
        send_bit(1); send_bit(1);
        sec_rst_act = 1;
        cyc(2);
        send_bit(1); send_bit(1);
        chk("R7 early stop keeps four bits", reg_rdata, 10'b0000001101);

        // R3: serial all-ones parks every output high
        do_reset();
        pri_rst_act = 0;
        cyc(2);
        for (int i = 0; i < N; i++) send_bit(1);
        chk("R3 all-ones mask", reg_rdata, '1);
        chk_out("R3 all parked high", '1, 0);

        // R8, R2, R3: sweep all mask values through the register port
        for (int v = 0; v < (1 << N); v++) begin
            reg_write(N'(v));
            chk("R8 read back", reg_rdata, N'(v));
            chk_out("R2 R3 sweep", N'(v), 0);
        end

        // R9, R10: every strap and power state combination
        reg_write(10'h2A5);
        for (int s = 0; s < 2; s++) begin
            for (int p = 0; p < 4; p++) begin
                ovr_strap = s[0];
                pwr_state = p[1:0];
                cyc(1);
                chk_out((s == 1 && p == 3) ? "R9 forced low" : "R10 no effect",
                        10'h2A5, (s == 1 && p == 3));
            end
        end

        // R11: override raised during a high phase waits for the falling edge
        ovr_strap = 0; pwr_state = 2'b00;
        reg_write('0);
        cyc(2);
        @(posedge clk); #1;
        ovr_strap = 1; pwr_state = 2'b11;
        #2;
        chk("R11 high phase completes", clk_out, '1);
        @(negedge clk); #2;
        chk("R11 forced after falling edge", clk_out, '0);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired actual=hung expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule